// File: doc/BRIEF.md
# Synchronous FIFO with Loadable Almost-Empty / Almost-Full Thresholds

This block is a single-clock first-in first-out buffer of 9-bit words whose depth is a power-of-two parameter between 256 and 8192 words (1024 by default). A word enters on a rising clock edge only when both of its write enables are high. A word leaves only when both of its read enables are high. The read data is registered and held until the next accepted read. An output-enable input gates the read bus: when it is low the bus is driven to zero and a companion enable output goes low. This models a three-state driver in a form that synthesises inside a chip.

Four status flags track the occupancy: empty, full, almost-empty and almost-full. The two "almost" thresholds are offsets held in registers. Each offset is built from a low byte and a high part, and the high part is as wide as the pointer bits above bit 7. The offsets are written over the data input bus. While the load input is high, every cycle with both write enables asserted stores the bus into the next offset part, in a fixed cyclic order, and no FIFO data is written. A synchronous reset empties the buffer, puts both offsets back to 7 and returns the loader to its first step.

Top module: `sync_fifo_pflag`

## Requirements
- R1: Synchronous reset (rst high at a clock edge) leaves empty=1, almost_empty=1, full=0 and almost_full=0 after that edge.
- R2: A word is stored only when wr_en_a and wr_en_b are both 1 (and load is 0); a single write enable stores nothing and empty stays 1.
- R3: A word is removed only when rd_en_a and rd_en_b are both 1; the removed word appears on dout after that clock edge, and words leave in the order they were written.
- R4: empty is 1 exactly when the occupancy is 0.
- R5: full is 1 exactly when the occupancy equals DEPTH; a write attempted while full is ignored and neither the stored data nor the occupancy changes.
- R6: A read attempted while empty is ignored: dout keeps its last value and empty stays 1.
- R7: almost_empty is 1 when occupancy <= empty offset; after reset the empty offset is 7 (1 at 7 words, 0 at 8).
- R8: almost_full is 1 when occupancy >= DEPTH - full offset; after reset the full offset is 7 (0 at DEPTH-8 words, 1 at DEPTH-7).
- R9: With load=1 and both write enables high, each cycle stores din into the next offset part in the order empty low byte, empty high part, full low byte, full high part, then back to the empty low byte; no FIFO word is stored in those cycles.
- R10: A low-byte step takes din[7:0]; a high-part step takes din[AW-9:0] (AW = log2 DEPTH, 2 bits at depth 1024) and ignores the higher din bits.
- R11: With out_en=0, dout reads 0 and dout_oe is 0; with out_en=1, dout_oe is 1 and dout shows the held read word.
- R12: Reset returns the offset loader to its first step, so the first load after reset writes the empty low byte even when a load sequence was partly done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the write and read sides |
| rst | input | 1 | Synchronous reset, active high |
| wr_en_a | input | 1 | First write enable |
| wr_en_b | input | 1 | Second write enable |
| load | input | 1 | Directs qualified writes to the offset registers |
| din | input | 9 | Write data, or offset part while loading |
| rd_en_a | input | 1 | First read enable |
| rd_en_b | input | 1 | Second read enable |
| out_en | input | 1 | Read bus enable |
| dout | output | 9 | Registered read data, zero when disabled |
| dout_oe | output | 1 | High when dout is actively driven |
| empty | output | 1 | No words stored |
| full | output | 1 | DEPTH words stored |
| almost_empty | output | 1 | Occupancy at or below the empty offset |
| almost_full | output | 1 | Occupancy at or above DEPTH minus the full offset |

## Verification
The hardest state to reach from the ports is an almost-empty threshold that needs the high offset part. That threshold lies above 255 words, so the bench has to drive the load sequencer through its low and high steps with junk in the unused upper bus bits. It then fills the buffer to the exact edge of the threshold. The almost-full edge near a full buffer is reached by plain filling of 1008 to 1017 words. The ignored write into a full buffer is then checked by draining all 1024 words and comparing the complete sequence.

// File: rtl/fifo_pflag_pkg.sv
package fifo_pflag_pkg;

    typedef enum logic [1:0] {
        STEP_EMPTY_LO = 2'd0,
        STEP_EMPTY_HI = 2'd1,
        STEP_FULL_LO  = 2'd2,
        STEP_FULL_HI  = 2'd3
    } load_step_e;

    localparam int OFFSET_DEFAULT = 7;

endpackage

// File: rtl/fifo_ram.sv
module fifo_ram #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store_q[waddr] <= wdata;
        end
    end

    assign rdata = store_q[raddr];

endmodule

// File: rtl/fifo_offset_regs.sv
module fifo_offset_regs
    import fifo_pflag_pkg::*;
#(
    parameter int DW = 9,
    parameter int OW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    input  logic [DW-1:0] din,
    output logic [OW-1:0] empty_off,
    output logic [OW-1:0] full_off
);

    localparam int HW = OW - 8;

    typedef struct packed {
        load_step_e    seq;
        logic [OW-1:0] eoff;
        logic [OW-1:0] foff;
    } off_state_t;

    off_state_t st_d, st_q;

    logic [OW-1:0] e_lo_merge, e_hi_merge, f_lo_merge, f_hi_merge;

    generate
        if (HW > 0) begin : g_split
            assign e_lo_merge = {st_q.eoff[OW-1:8], din[7:0]};
            assign f_lo_merge = {st_q.foff[OW-1:8], din[7:0]};
            assign e_hi_merge = {din[HW-1:0], st_q.eoff[7:0]};
            assign f_hi_merge = {din[HW-1:0], st_q.foff[7:0]};
        end else begin : g_byte_only
            assign e_lo_merge = din[7:0];
            assign f_lo_merge = din[7:0];
            assign e_hi_merge = st_q.eoff;
            assign f_hi_merge = st_q.foff;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (step) begin
            unique case (st_q.seq)
                STEP_EMPTY_LO: begin
                    st_d.eoff = e_lo_merge;
                    st_d.seq  = STEP_EMPTY_HI;
                end
                STEP_EMPTY_HI: begin
                    st_d.eoff = e_hi_merge;
                    st_d.seq  = STEP_FULL_LO;
                end
                STEP_FULL_LO: begin
                    st_d.foff = f_lo_merge;
                    st_d.seq  = STEP_FULL_HI;
                end
                STEP_FULL_HI: begin
                    st_d.foff = f_hi_merge;
                    st_d.seq  = STEP_EMPTY_LO;
                end
                default: st_d.seq = STEP_EMPTY_LO;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.seq  <= STEP_EMPTY_LO;
            st_q.eoff <= OW'(OFFSET_DEFAULT);
            st_q.foff <= OW'(OFFSET_DEFAULT);
        end else begin
            st_q <= st_d;
        end
    end

    assign empty_off = st_q.eoff;
    assign full_off  = st_q.foff;

endmodule

// File: rtl/fifo_flags.sv
module fifo_flags #(
    parameter int DEPTH = 1024,
    parameter int CW    = $clog2(DEPTH) + 1,
    parameter int OW    = 10
) (
    input  logic [CW-1:0] occ,
    input  logic [OW-1:0] empty_off,
    input  logic [OW-1:0] full_off,
    output logic          empty,
    output logic          full,
    output logic          almost_empty,
    output logic          almost_full
);

    localparam int SW = ((CW > OW) ? CW : OW) + 1;

    logic [SW-1:0] occ_w, eoff_w, reach_w;

    always_comb begin
        occ_w        = SW'(occ);
        eoff_w       = SW'(empty_off);
        reach_w      = occ_w + SW'(full_off);
        empty        = (occ == '0);
        full         = (occ_w == SW'(DEPTH));
        almost_empty = (occ_w <= eoff_w);
        almost_full  = (reach_w >= SW'(DEPTH));
    end

endmodule

// File: rtl/sync_fifo_pflag.sv
module sync_fifo_pflag
    import fifo_pflag_pkg::*;
#(
    parameter int WIDTH = 9,
    parameter int DEPTH = 1024
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en_a,
    input  logic             wr_en_b,
    input  logic             load,
    input  logic [WIDTH-1:0] din,
    input  logic             rd_en_a,
    input  logic             rd_en_b,
    input  logic             out_en,
    output logic [WIDTH-1:0] dout,
    output logic             dout_oe,
    output logic             empty,
    output logic             full,
    output logic             almost_empty,
    output logic             almost_full
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam int OW = (AW > 8) ? AW : 8;

    typedef struct packed {
        logic [AW-1:0]    wptr;
        logic [AW-1:0]    rptr;
        logic [CW-1:0]    occ;
        logic [WIDTH-1:0] rdata;
    } core_state_t;

    core_state_t cs_d, cs_q;

    logic             wr_qual, rd_qual, push, pop, off_step;
    logic [WIDTH-1:0] ram_rdata;
    logic [OW-1:0]    empty_off, full_off;
    logic [CW-1:0]    occ;

    assign wr_qual  = wr_en_a & wr_en_b;
    assign rd_qual  = rd_en_a & rd_en_b;
    assign off_step = wr_qual & load;
    assign push     = wr_qual & ~load & ~full;
    assign pop      = rd_qual & ~empty;
    assign occ      = cs_q.occ;

    fifo_ram #(
        .WIDTH (WIDTH),
        .DEPTH (DEPTH),
        .AW    (AW)
    ) u_ram (
        .clk   (clk),
        .we    (push),
        .waddr (cs_q.wptr),
        .wdata (din),
        .raddr (cs_q.rptr),
        .rdata (ram_rdata)
    );

    fifo_offset_regs #(
        .DW (WIDTH),
        .OW (OW)
    ) u_offsets (
        .clk       (clk),
        .rst       (rst),
        .step      (off_step),
        .din       (din),
        .empty_off (empty_off),
        .full_off  (full_off)
    );

    fifo_flags #(
        .DEPTH (DEPTH),
        .CW    (CW),
        .OW    (OW)
    ) u_flags (
        .occ          (occ),
        .empty_off    (empty_off),
        .full_off     (full_off),
        .empty        (empty),
        .full         (full),
        .almost_empty (almost_empty),
        .almost_full  (almost_full)
    );

    always_comb begin
        cs_d = cs_q;
        if (push) begin
            cs_d.wptr = cs_q.wptr + 1'b1;
        end
        if (pop) begin
            cs_d.rptr  = cs_q.rptr + 1'b1;
            cs_d.rdata = ram_rdata;
        end
        unique case ({push, pop})
            2'b10:   cs_d.occ = cs_q.occ + 1'b1;
            2'b01:   cs_d.occ = cs_q.occ - 1'b1;
            default: cs_d.occ = cs_q.occ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q <= '0;
        end else begin
            cs_q <= cs_d;
        end
    end

    assign dout_oe = out_en;
    assign dout    = out_en ? cs_q.rdata : '0;

endmodule

// File: rtl/fifo_pflag_chk.sv
module fifo_pflag_chk #(
    parameter int DEPTH = 1024
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     wr_en_a,
    input logic                     wr_en_b,
    input logic                     load,
    input logic                     rd_en_a,
    input logic                     rd_en_b,
    input logic                     empty,
    input logic                     full,
    input logic                     almost_empty,
    input logic                     almost_full,
    input logic [$clog2(DEPTH):0]   occ
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (empty && almost_empty && !full));

    // R4
    no_empty_full_chk: assert property (@(posedge clk) disable iff (rst)
        !(empty && full));

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        occ <= ($clog2(DEPTH) + 1)'(DEPTH));

    // R5
    full_write_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (full && !(rd_en_a && rd_en_b)) |=> (full && $stable(occ)));

    // R6
    empty_read_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (empty && !(wr_en_a && wr_en_b && !load)) |=> empty);

    // R7
    empty_implies_ae_chk: assert property (@(posedge clk) disable iff (rst)
        empty |-> almost_empty);

    // R8
    full_implies_af_chk: assert property (@(posedge clk) disable iff (rst)
        full |-> almost_full);

    // R9
    load_no_store_chk: assert property (@(posedge clk) disable iff (rst)
        (load && !(rd_en_a && rd_en_b)) |=> $stable(occ));

endmodule

bind sync_fifo_pflag fifo_pflag_chk #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en_a      (wr_en_a),
    .wr_en_b      (wr_en_b),
    .load         (load),
    .rd_en_a      (rd_en_a),
    .rd_en_b      (rd_en_b),
    .empty        (empty),
    .full         (full),
    .almost_empty (almost_empty),
    .almost_full  (almost_full),
    .occ          (occ)
);

// File: tb/tb_sync_fifo_pflag.sv
module tb_sync_fifo_pflag;

    localparam int DEPTH = 1024;
    localparam int W     = 9;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en_a = 1'b0, wr_en_b = 1'b0, load = 1'b0;
    logic [W-1:0] din = '0;
    logic         rd_en_a = 1'b0, rd_en_b = 1'b0, out_en = 1'b1;
    logic [W-1:0] dout;
    logic         dout_oe, empty, full, almost_empty, almost_full;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    sync_fifo_pflag #(.WIDTH(W), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .wr_en_a(wr_en_a), .wr_en_b(wr_en_b),
        .load(load), .din(din), .rd_en_a(rd_en_a), .rd_en_b(rd_en_b),
        .out_en(out_en), .dout(dout), .dout_oe(dout_oe), .empty(empty),
        .full(full), .almost_empty(almost_empty), .almost_full(almost_full)
    );

    function automatic logic [W-1:0] pat(input int i);
        return W'(i * 7 + 3);
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick();
        rst = 1'b0;
    endtask

    task automatic push(input logic [W-1:0] d);
        wr_en_a = 1'b1; wr_en_b = 1'b1; din = d;
        tick();
        wr_en_a = 1'b0; wr_en_b = 1'b0;
    endtask

    task automatic pop();
        rd_en_a = 1'b1; rd_en_b = 1'b1;
        tick();
        rd_en_a = 1'b0; rd_en_b = 1'b0;
    endtask

    task automatic load_part(input logic [W-1:0] d);
        load = 1'b1; wr_en_a = 1'b1; wr_en_b = 1'b1; din = d;
        tick();
        load = 1'b0; wr_en_a = 1'b0; wr_en_b = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 empty", empty, 1);
        chk("R1 almost_empty", almost_empty, 1);
        chk("R1 full", full, 0);
        chk("R1 almost_full", almost_full, 0);
    endtask

    task automatic t_enables_and_oe();
        do_reset();
        wr_en_a = 1'b1; din = 9'h005; tick(); wr_en_a = 1'b0;
        chk("R2 single wr_en_a", empty, 1);
        wr_en_b = 1'b1; tick(); wr_en_b = 1'b0;
        chk("R2 single wr_en_b", empty, 1);
        push(9'h0AB);
        chk("R2 R4 both enables store", empty, 0);
        rd_en_a = 1'b1; tick(); rd_en_a = 1'b0;
        chk("R3 single rd_en_a", empty, 0);
        pop();
        chk("R3 read data", dout, 9'h0AB);
        chk("R4 empty after drain", empty, 1);
        pop();
        chk("R6 dout held on empty read", dout, 9'h0AB);
        chk("R6 empty held", empty, 1);
        out_en = 1'b0; #1;
        chk("R11 dout gated", dout, 0);
        chk("R11 dout_oe low", dout_oe, 0);
        out_en = 1'b1; #1;
        chk("R11 dout restored", dout, 9'h0AB);
        chk("R11 dout_oe high", dout_oe, 1);
    endtask

    task automatic t_order();
        int bad = 0;
        do_reset();
        for (int i = 0; i < 5; i++) push(pat(i + 40));
        for (int i = 0; i < 5; i++) begin
            pop();
            if (dout != pat(i + 40)) bad++;
        end
        chk("R3 order of five words", bad, 0);
    endtask

    task automatic t_almost_empty_default();
        do_reset();
        for (int i = 0; i < 7; i++) push(pat(i));
        chk("R7 ae at 7 words", almost_empty, 1);
        push(pat(7));
        chk("R7 ae at 8 words", almost_empty, 0);
    endtask

    task automatic t_full();
        int bad = 0;
        do_reset();
        for (int i = 0; i < DEPTH - 8; i++) push(pat(i));
        chk("R8 af at DEPTH-8", almost_full, 0);
        push(pat(DEPTH - 8));
        chk("R8 af at DEPTH-7", almost_full, 1);
        for (int i = DEPTH - 7; i < DEPTH - 1; i++) push(pat(i));
        chk("R5 not full at DEPTH-1", full, 0);
        push(pat(DEPTH - 1));
        chk("R5 full at DEPTH", full, 1);
        push(9'h1AA);
        chk("R5 full after ignored write", full, 1);
        for (int i = 0; i < DEPTH; i++) begin
            pop();
            if (dout != pat(i)) bad++;
        end
        chk("R5 stored data intact", bad, 0);
        chk("R5 R4 empty after drain", empty, 1);
    endtask

    task automatic t_load_order();
        do_reset();
        load_part(9'd3);
        load_part(9'd0);
        load_part(9'd16);
        load_part(9'd0);
        chk("R9 no data stored while loading", empty, 1);
        for (int i = 0; i < 3; i++) push(pat(i));
        chk("R9 ae at empty offset 3", almost_empty, 1);
        push(pat(3));
        chk("R9 ae above empty offset 3", almost_empty, 0);
        for (int i = 4; i < DEPTH - 17; i++) push(pat(i));
        chk("R9 af below DEPTH-16", almost_full, 0);
        push(9'h000);
        chk("R9 af at DEPTH-16", almost_full, 1);
    endtask

    task automatic t_load_high_part();
        do_reset();
        load_part(9'h002);
        load_part(9'h1FD);
        for (int i = 0; i < 258; i++) push(pat(i));
        chk("R10 ae at offset 258", almost_empty, 1);
        push(pat(258));
        chk("R10 ae at 259 words", almost_empty, 0);
    endtask

    task automatic t_load_wrap();
        do_reset();
        load_part(9'd7);
        load_part(9'd0);
        load_part(9'd7);
        load_part(9'd0);
        load_part(9'd2);
        for (int i = 0; i < 2; i++) push(pat(i));
        chk("R9 wrap ae at 2", almost_empty, 1);
        push(pat(2));
        chk("R9 wrap ae at 3", almost_empty, 0);
    endtask

    task automatic t_reset_sequencer();
        do_reset();
        load_part(9'h020);
        do_reset();
        load_part(9'd4);
        for (int i = 0; i < 4; i++) push(pat(i));
        chk("R12 first step after reset is empty low", almost_empty, 1);
        push(pat(4));
        chk("R12 ae at 5 words", almost_empty, 0);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        tick();
        t_reset();
        t_enables_and_oe();
        t_order();
        t_almost_empty_default();
        t_full();
        t_load_order();
        t_load_high_part();
        t_load_wrap();
        t_reset_sequencer();
        finish_run();
    end

endmodule